// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog that software must service on time, and not too early. Its count is paced by a slow-clock strobe, `slck_en`, which pulses once per period of a 32768 Hz slow clock. A prescaler divides these strobes so that the down-counter steps 256 times per second. A timeout of N seconds (1 to 16) therefore uses a reload value of N*256-1.

Software services the watchdog by writing a keyed restart command. If the restart arrives while the count is still above a programmed window value, it counts as a fault, just as an underflow does. A fault can drive a level interrupt or a stretched reset-request pulse. After any restart, register writes are locked out for three slow-clock periods. Two halt controls can freeze the count while the system is idle or under debug.

Top module: `wdog_top`

## Requirements
- R1: After reset the MODE register (address 1) reads 0x82FF_FFFF, STATUS (address 2) reads 0, and `fault_irq` and `reset_req` are low. The MODE layout is reload in bits 11:0, window in bits 23:12, interrupt enable in bit 24, reset enable in bit 25, idle halt in bit 26, debug halt in bit 27 and disable in bit 31.
- R2: While enabled, the counter steps down once every PRESCALE slow-clock strobes. An underflow happens on the (reload+1)*PRESCALE-th strobe after a restart, and the counter then reloads. A reload of 0 fires after PRESCALE strobes.
- R3: A write to CTRL (address 0) restarts the counter from the reload value and clears the prescaler only when bits 31:24 equal 0xA5 and bit 0 is 1. Any other CTRL write has no effect.
- R4: For three slow-clock strobes after any restart, writes to CTRL and MODE are dropped.
- R5: While MODE bit 31 is set the counter does not move. A MODE write with bit 31 set leaves the reload and window fields unchanged and updates the other bits.
- R6: A MODE write with bit 31 clear restarts the counter from the newly written reload value.
- R7: A keyed restart while enabled and while the count is greater than the window field sets STATUS bit 1 and raises a fault. A restart with the count equal to or below the window does not.
- R8: STATUS bit 0 records an underflow and bit 1 a window error. Reading address 2 clears both bits. A fault that occurs in the same cycle as the read stays recorded.
- R9: With bit 24 set and bit 25 clear, `fault_irq` is high from the cycle after a fault until STATUS is read.
- R10: With bit 25 set, a fault drives `reset_req` high for 4 cycles, starting the cycle after the fault, and `fault_irq` stays low.
- R11: Bit 26 freezes the count while `idle_in` is high, and bit 27 freezes it while `debug_in` is high. A halt input whose bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| slck_en | input | 1 | One-cycle strobe per slow-clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears STATUS at address 2) |
| bus_addr | input | 2 | Register address: 0 CTRL, 1 MODE, 2 STATUS |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the read cycle |
| idle_in | input | 1 | System idle indication |
| debug_in | input | 1 | Debugger halt indication |
| fault_irq | output | 1 | Fault interrupt, level |
| reset_req | output | 1 | Stretched reset-request pulse |

## Verification
The status read-and-clear can land in the same clock as a new fault. The bench provokes this by asserting the final counting strobe and the STATUS read together. In that cycle the read must return the old, clear value, and a second read must show the underflow bit. Lockout boundaries and window boundaries are probed one strobe apart. Random window/reload/kick-time triples are judged by a bench function that derives the expected count from the strobes delivered.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 32;
    localparam logic [7:0] KICK_KEY = 8'hA5;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_MODE = 2'd1,
        ADR_STAT = 2'd2,
        ADR_NONE = 2'd3
    } addr_e;

    typedef struct packed {
        logic             off;
        logic [2:0]       rsvd;
        logic             dbg_halt;
        logic             idle_halt;
        logic             rst_en;
        logic             irq_en;
        logic [CNT_W-1:0] window;
        logic [CNT_W-1:0] reload;
    } mode_t;

    typedef struct packed {
        logic win_err;
        logic underflow;
    } stat_t;

    function automatic logic [CNT_W-1:0] secs_to_reload(input int unsigned s);
        return (s == 0) ? '0 : CNT_W'(s * 256 - 1);
    endfunction

    localparam mode_t MODE_RST = '{
        off: 1'b1, rsvd: 3'b000, dbg_halt: 1'b0, idle_halt: 1'b0,
        rst_en: 1'b1, irq_en: 1'b0,
        window: secs_to_reload(16), reload: secs_to_reload(16)
    };

    // Fields are frozen whenever the written word keeps the block disabled.
    function automatic mode_t merge_mode(input mode_t cur, input logic [DATA_W-1:0] wd);
        mode_t nxt;
        nxt      = mode_t'(wd);
        nxt.rsvd = '0;
        if (nxt.off) begin
            nxt.reload = cur.reload;
            nxt.window = cur.window;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
    import wdog_pkg::*;
#(
    parameter int LOCK_SLCK = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slck_en,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output mode_t             mode_q,
    output logic              kick,
    output logic              mode_load,
    output logic [CNT_W-1:0]  load_val,
    output logic              locked
);
    localparam int LW = $clog2(LOCK_SLCK + 1);

    logic [LW-1:0] lock_cnt;
    addr_e         a_sel;
    mode_t         mode_new;
    logic          wr_ok;
    logic          mode_wr;

    assign a_sel     = addr_e'(bus_addr);
    assign locked    = (lock_cnt != '0);
    assign wr_ok     = bus_wr & ~locked;
    assign mode_new  = merge_mode(mode_q, bus_wdata);
    assign kick      = wr_ok && (a_sel == ADR_CTRL) &&
                       (bus_wdata[31:24] == KICK_KEY) && bus_wdata[0];
    assign mode_wr   = wr_ok && (a_sel == ADR_MODE);
    assign mode_load = mode_wr & ~mode_new.off;
    assign load_val  = mode_load ? mode_new.reload : mode_q.reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_RST;
            lock_cnt <= '0;
        end else begin
            if (mode_wr) begin
                mode_q <= mode_new;
            end
            if (kick || mode_load) begin
                lock_cnt <= LW'(LOCK_SLCK);
            end else if (slck_en && locked) begin
                lock_cnt <= lock_cnt - 1'b1;
            end
        end
    end

    p_lock_drops_mode_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && bus_wr && (a_sel == ADR_MODE)) |=> (mode_q == $past(mode_q)));

    p_lock_after_kick_r4: assert property (@(posedge clk) disable iff (rst)
        kick |=> locked);

    p_off_keeps_fields_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (a_sel == ADR_MODE) && bus_wdata[31]) |=>
        ((mode_q.reload == $past(mode_q.reload)) && (mode_q.window == $past(mode_q.window))));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int PRESCALE = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slck_en,
    input  logic             enable,
    input  logic             idle_hold,
    input  logic             dbg_hold,
    input  logic             idle_in,
    input  logic             debug_in,
    input  logic             kick,
    input  logic             mode_load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] window,
    output logic             underflow,
    output logic             win_err
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    logic [PW-1:0]    pre;
    logic [CNT_W-1:0] cnt;
    logic             restart;
    logic             halted;
    logic             run;
    logic             wrap;
    logic             tick;

    assign restart   = kick | mode_load;
    assign halted    = (idle_hold & idle_in) | (dbg_hold & debug_in);
    assign run       = enable & ~halted;
    assign wrap      = (pre == PRE_LAST);
    assign tick      = run & slck_en & wrap & ~restart;
    assign underflow = tick & (cnt == '0);
    assign win_err   = kick & enable & (cnt > window);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
            cnt <= MODE_RST.reload;
        end else if (restart) begin
            pre <= '0;
            cnt <= load_val;
        end else if (run && slck_en) begin
            pre <= wrap ? '0 : pre + PW'(1);
            if (wrap) begin
                cnt <= (cnt == '0) ? reload : cnt - 1'b1;
            end
        end
    end

    p_stopped_when_off_r5: assert property (@(posedge clk) disable iff (rst)
        (!enable && !restart) |=> $stable(cnt));

    p_frozen_on_halt_r11: assert property (@(posedge clk) disable iff (rst)
        (enable && halted && !restart) |=> ($stable(cnt) && $stable(pre)));

    p_underflow_reload_r2: assert property (@(posedge clk) disable iff (rst)
        underflow |=> (cnt == $past(reload)));

endmodule

// File: rtl/wdog_fault.sv
module wdog_fault
    import wdog_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  underflow,
    input  logic  win_err,
    input  logic  rd_clr,
    input  logic  irq_en,
    input  logic  rst_en,
    output stat_t status,
    output logic  fault_irq,
    output logic  reset_req
);
    localparam int RW = $clog2(RST_CYC + 1);

    logic [RW-1:0] hold;
    stat_t         flag_set;
    logic          fault;

    assign flag_set  = '{win_err: win_err, underflow: underflow};
    assign fault     = underflow | win_err;
    assign reset_req = (hold != '0);
    assign fault_irq = irq_en & ~rst_en & (|status);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            hold   <= '0;
        end else begin
            status <= rd_clr ? flag_set : stat_t'(status | flag_set);
            if (fault && rst_en) begin
                hold <= RW'(RST_CYC);
            end else if (reset_req) begin
                hold <= hold - 1'b1;
            end
        end
    end

    p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (status.underflow && !rd_clr) |=> status.underflow);

    p_rst_min_len_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_req) |=> reset_req);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int PRESCALE  = 128,
    parameter int LOCK_SLCK = 3,
    parameter int RST_CYC   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slck_en,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        idle_in,
    input  logic        debug_in,
    output logic        fault_irq,
    output logic        reset_req
);
    mode_t            mode_q;
    stat_t            status;
    logic             kick;
    logic             mode_load;
    logic             locked;
    logic [CNT_W-1:0] load_val;
    logic             underflow;
    logic             win_err;
    logic             rd_clr;

    assign rd_clr = bus_rd && (addr_e'(bus_addr) == ADR_STAT);

    wdog_regif #(.LOCK_SLCK(LOCK_SLCK)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .slck_en   (slck_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mode_q    (mode_q),
        .kick      (kick),
        .mode_load (mode_load),
        .load_val  (load_val),
        .locked    (locked)
    );

    wdog_counter #(.PRESCALE(PRESCALE)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .slck_en   (slck_en),
        .enable    (~mode_q.off),
        .idle_hold (mode_q.idle_halt),
        .dbg_hold  (mode_q.dbg_halt),
        .idle_in   (idle_in),
        .debug_in  (debug_in),
        .kick      (kick),
        .mode_load (mode_load),
        .load_val  (load_val),
        .reload    (mode_q.reload),
        .window    (mode_q.window),
        .underflow (underflow),
        .win_err   (win_err)
    );

    wdog_fault #(.RST_CYC(RST_CYC)) u_fault (
        .clk       (clk),
        .rst       (rst),
        .underflow (underflow),
        .win_err   (win_err),
        .rd_clr    (rd_clr),
        .irq_en    (mode_q.irq_en),
        .rst_en    (mode_q.rst_en),
        .status    (status),
        .fault_irq (fault_irq),
        .reset_req (reset_req)
    );

    always_comb begin
        case (addr_e'(bus_addr))
            ADR_MODE: bus_rdata = mode_q;
            ADR_STAT: bus_rdata = {30'd0, status};
            default:  bus_rdata = '0;
        endcase
    end

    p_kick_blocked_when_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && kick) |-> 1'b0 == 1'b1 ? 1'b0 : !locked);

endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slck_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        idle_in = 1'b0;
    logic        debug_in = 1'b0;
    logic        fault_irq;
    logic        reset_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] v;

    always #2 clk = ~clk;

    wdog_top #(.PRESCALE(PS), .LOCK_SLCK(3), .RST_CYC(4)) i_wdog_top (
        .clk(clk), .rst(rst), .slck_en(slck_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .idle_in(idle_in), .debug_in(debug_in), .fault_irq(fault_irq), .reset_req(reset_req)
    );

    function automatic logic [31:0] mode_word(input bit off, input bit dbg, input bit idl,
                                              input bit rse, input bit irq,
                                              input int unsigned win, input int unsigned rel);
        return {off, 3'b000, dbg, idl, rse, irq, win[11:0], rel[11:0]};
    endfunction

    function automatic bit exp_winerr(input int unsigned rel, input int unsigned win,
                                      input int unsigned k);
        return (rel - k / PS) > win;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            slck_en = 1'b1;
            cyc();
        end
        slck_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        cyc();
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        idle(3);
        rst = 1'b0;
        cyc();
        // R1 reset state
        check("R1 reset_req", {31'd0, reset_req}, 32'd0);
        check("R1 fault_irq", {31'd0, fault_irq}, 32'd0);
        rd(2'd1, v); check("R1 mode", v, 32'h82FF_FFFF);
        rd(2'd2, v); check("R1 status", v, 32'd0);

        // R5 fields held while disabled
        wr(2'd1, mode_word(1, 0, 0, 0, 1, 5, 10));
        rd(2'd1, v); check("R5 fields kept", v, 32'h81FF_FFFF);

        // R6/R2/R10: enable reload 5
        wr(2'd1, mode_word(0, 0, 0, 1, 0, 5, 5));
        pulses(23); check("R2 no early fire", {31'd0, reset_req}, 32'd0);
        pulses(1);  check("R2 fire at (R+1)*P", {31'd0, reset_req}, 32'd1);
        idle(3);    check("R10 pulse cycle 4", {31'd0, reset_req}, 32'd1);
        idle(1);    check("R10 pulse ends", {31'd0, reset_req}, 32'd0);
        rd(2'd2, v); check("R8 underflow bit", v, 32'd1);
        rd(2'd2, v); check("R8 clear on read", v, 32'd0);

        // R3 bad key and missing restart bit ignored
        pulses(20);
        wr(2'd0, 32'h5A00_0001);
        wr(2'd0, 32'hA500_0000);
        pulses(3); check("R3 bad kick ignored pre", {31'd0, reset_req}, 32'd0);
        pulses(1); check("R3 bad kick ignored", {31'd0, reset_req}, 32'd1);
        idle(5); rd(2'd2, v);
        // R3 good kick
        pulses(20);
        wr(2'd0, 32'hA500_0001);
        pulses(23); check("R3 kick postpones", {31'd0, reset_req}, 32'd0);
        pulses(1);  check("R3 kick reload", {31'd0, reset_req}, 32'd1);
        idle(5); rd(2'd2, v);

        // R4 lockout
        wr(2'd0, 32'hA500_0001);
        pulses(2);
        wr(2'd1, mode_word(0, 0, 0, 1, 0, 7, 7));
        rd(2'd1, v); check("R4 mode write dropped", v, mode_word(0, 0, 0, 1, 0, 5, 5));
        pulses(1);
        wr(2'd1, mode_word(0, 0, 0, 1, 0, 7, 7));
        rd(2'd1, v); check("R4 mode write after lock", v, mode_word(0, 0, 0, 1, 0, 7, 7));
        pulses(2);
        wr(2'd0, 32'hA500_0001);
        pulses(29); check("R4 kick dropped pre", {31'd0, reset_req}, 32'd0);
        pulses(1);  check("R4 kick dropped", {31'd0, reset_req}, 32'd1);
        idle(5); rd(2'd2, v);

        // R5 disable stops, R6 reload from new value
        wr(2'd1, mode_word(1, 0, 0, 1, 0, 2, 2));
        rd(2'd1, v); check("R5 fields kept 2", v, mode_word(1, 0, 0, 1, 0, 7, 7));
        pulses(60);
        check("R5 no fire while off", {31'd0, reset_req}, 32'd0);
        rd(2'd2, v); check("R5 status while off", v, 32'd0);
        wr(2'd1, mode_word(0, 0, 0, 1, 0, 3, 3));
        pulses(15); check("R6 new reload pre", {31'd0, reset_req}, 32'd0);
        pulses(1);  check("R6 new reload", {31'd0, reset_req}, 32'd1);
        idle(5); rd(2'd2, v);

        // R11 idle halt, debug without its bit
        wr(2'd1, mode_word(0, 0, 1, 1, 0, 3, 3));
        pulses(3);
        idle_in = 1'b1;
        pulses(30); check("R11 idle freeze", {31'd0, reset_req}, 32'd0);
        idle_in = 1'b0; debug_in = 1'b1;
        pulses(12); check("R11 debug no bit pre", {31'd0, reset_req}, 32'd0);
        pulses(1);  check("R11 debug no bit", {31'd0, reset_req}, 32'd1);
        debug_in = 1'b0;
        idle(5); rd(2'd2, v);
        // R11 debug halt
        wr(2'd1, mode_word(0, 1, 0, 1, 0, 3, 3));
        pulses(3);
        debug_in = 1'b1;
        pulses(30); check("R11 debug freeze", {31'd0, reset_req}, 32'd0);
        debug_in = 1'b0;
        pulses(12); check("R11 resume pre", {31'd0, reset_req}, 32'd0);
        pulses(1);  check("R11 resume", {31'd0, reset_req}, 32'd1);
        idle(5); rd(2'd2, v);

        // R2 reload 0
        wr(2'd1, mode_word(0, 0, 0, 1, 0, 0, 0));
        pulses(3); check("R2 zero reload pre", {31'd0, reset_req}, 32'd0);
        pulses(1); check("R2 zero reload", {31'd0, reset_req}, 32'd1);
        idle(5); rd(2'd2, v);

        // R7 window, R9 interrupt
        wr(2'd1, mode_word(0, 0, 0, 0, 1, 8, 15));
        pulses(27);
        wr(2'd0, 32'hA500_0001);
        check("R9 irq on window error", {31'd0, fault_irq}, 32'd1);
        check("R9 no reset_req", {31'd0, reset_req}, 32'd0);
        rd(2'd2, v); check("R7 window error bit", v, 32'd2);
        check("R9 irq cleared by read", {31'd0, fault_irq}, 32'd0);
        pulses(28);
        wr(2'd0, 32'hA500_0001);
        rd(2'd2, v); check("R7 count equal to window ok", v, 32'd0);

        // R10 reset precedence over interrupt
        pulses(3);
        wr(2'd1, mode_word(0, 0, 0, 1, 1, 8, 15));
        pulses(3);
        wr(2'd0, 32'hA500_0001);
        check("R10 reset wins", {31'd0, reset_req}, 32'd1);
        check("R10 irq low", {31'd0, fault_irq}, 32'd0);
        idle(5);
        rd(2'd2, v); check("R10 status", v, 32'd2);

        // R8 read and fault in the same cycle
        pulses(3);
        wr(2'd1, mode_word(0, 0, 0, 0, 1, 3, 3));
        pulses(15);
        slck_en = 1'b1; bus_rd = 1'b1; bus_addr = 2'd2;
        #1; v = bus_rdata;
        cyc();
        slck_en = 1'b0; bus_rd = 1'b0;
        check("R8 same-cycle read old", v, 32'd0);
        rd(2'd2, v); check("R8 same-cycle fault kept", v, 32'd1);

        // R7 random window trials
        for (int i = 0; i < 40; i++) begin
            int unsigned r, w, k;
            bit e;
            r = 8 + $urandom % 33;
            w = $urandom % (r + 1);
            k = 3 + $urandom % ((r + 1) * PS - 3);
            e = exp_winerr(r, w, k);
            wr(2'd1, mode_word(0, 0, 0, 0, 1, w, r));
            pulses(k);
            wr(2'd0, 32'hA500_0001);
            check("R7 random irq", {31'd0, fault_irq}, {31'd0, e});
            rd(2'd2, v); check("R7 random status", v, {30'd0, e, 1'b0});
            pulses(3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule